// File: doc/BRIEF.md
# Memory Request Slot Table

This block keeps a small pool of slots that a pipeline uses to follow data cache accesses while they are in flight. Each slot records the owning thread, the instruction's sequence tag, the schedule index and a command code. It also tracks where the access stands: waiting on translation, waiting on memory, squashed while still owed a reply, or done. The pipeline takes a slot on allocation, finds it again by tag and schedule index, and moves it along with per-slot event masks: translation miss and resume, issue, completion check, memory reply, and release.

Squash broadcasts carry a thread and a sequence threshold. An optional flag raises the threshold by one, so that the instruction that stalled on memory survives. A squashed slot with nothing outstanding is released at once. A slot that still owes a translation resume or a memory reply stays held, marked squashed, until that event arrives. A reply to a squashed slot is dropped and is not forwarded.

Each slot runs a six-state machine. The states are FREE, READY, TLB_WAIT, MEM_WAIT, DRAIN_TLB and DRAIN_MEM. The transitions are:
- FREE to READY on allocation.
- READY to FREE on release or squash, to TLB_WAIT on a translation miss, and to MEM_WAIT on issue.
- TLB_WAIT to READY on resume, or to DRAIN_TLB on squash. Resume and squash in the same cycle go to FREE.
- MEM_WAIT to READY on reply, or to DRAIN_MEM on squash. Reply and squash in the same cycle go to FREE.
- DRAIN_TLB to FREE on resume.
- DRAIN_MEM to FREE on reply.

Top module: `mem_slot_table`

## Requirements
- R1: After reset every slot is free (`slot_busy`=0), no thread is blocked (`thr_blocked`=0), and no slot shows squashed, done or memory-stall.
- R2: An allocation request is granted in the same cycle when some slot is free and the requesting thread is not blocked. It takes the lowest-numbered free slot, reported on `alloc_slot`. The slot is busy from the next cycle with done=0 and memory-stall=0. With all slots busy, `alloc_gnt`=0 and nothing changes.
- R3: A lookup hits only on a busy slot whose stored tag equals `lk_seq` and whose stored schedule index equals `lk_idx`. `lk_slot` gives the lowest such slot.
- R4: A squash selects every live, not yet squashed slot whose thread equals `sq_tid` and whose tag is strictly greater than the effective threshold. The effective threshold is `sq_thr`, or `sq_thr`+1 when `sq_memstall`=1, compared unsigned without wrap.
- R5: A selected slot in READY is released at the next edge.
- R6: A selected slot in TLB_WAIT or MEM_WAIT stays busy with `slot_sqd`=1. It is released one edge after its translation resume or memory reply.
- R7: A slot already shown squashed is unaffected by later squashes.
- R8: A completion check on a slot in MEM_WAIT with no reply in that cycle sets memory-stall=1 and done=0. A reply to a MEM_WAIT slot raises `rsp_fwd` for that slot in the same cycle, then sets done=1 and memory-stall=0 and returns the slot to READY.
- R9: A reply to a squashed slot in DRAIN_MEM leaves `rsp_fwd`=0 for that slot and releases the slot.
- R10: A translation miss on a READY slot blocks the slot's thread from the next cycle, and allocations for that thread are refused. Either a resume of that slot or a squash of it while in TLB_WAIT unblocks the thread.
- R11: A squash and a reply in the same cycle on a MEM_WAIT slot forward the reply (`rsp_fwd`=1) and release the slot at that edge.
- R12: The release mask frees READY slots, and several slots may be freed in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Allocation request |
| alloc_tid | input | TID_W | Thread of the new request |
| alloc_seq | input | SEQ_W | Sequence tag of the new request |
| alloc_idx | input | IDX_W | Schedule index of the new request |
| alloc_cmd | input | CMD_W | Command code of the new request |
| alloc_gnt | output | 1 | Allocation granted this cycle |
| alloc_slot | output | SLOT_W | Slot granted |
| lk_seq | input | SEQ_W | Lookup tag |
| lk_idx | input | IDX_W | Lookup schedule index |
| lk_hit | output | 1 | Lookup found a slot |
| lk_slot | output | SLOT_W | Slot found |
| tlb_miss_mask | input | NSLOTS | Per-slot translation miss |
| tlb_done_mask | input | NSLOTS | Per-slot translation resume |
| issue_mask | input | NSLOTS | Per-slot issue to memory |
| chk_mask | input | NSLOTS | Per-slot completion check |
| rsp_mask | input | NSLOTS | Per-slot memory reply |
| free_mask | input | NSLOTS | Per-slot release |
| sq_vld | input | 1 | Squash broadcast |
| sq_tid | input | TID_W | Squashed thread |
| sq_thr | input | SEQ_W | Squash threshold |
| sq_memstall | input | 1 | Raise threshold by one |
| rsp_fwd | output | NSLOTS | Reply forwarded to the pipeline |
| slot_busy | output | NSLOTS | Slot held |
| slot_sqd | output | NSLOTS | Slot squashed and draining |
| slot_done | output | NSLOTS | Slot access completed |
| slot_mstall | output | NSLOTS | Slot stalled on memory |
| thr_blocked | output | NTHR | Thread blocked by translation miss |

## Verification
Two events can land on the same slot in one edge: a squash broadcast together with a memory reply, and a squash together with a translation resume. The bench provokes the first by raising the squash and the reply for a MEM_WAIT slot in the same cycle. It judges that `rsp_fwd` is high in that cycle and that the slot is free afterwards. It also raises two releases in one cycle and checks that the next allocation takes the lower index. Repeated squashes are aimed at draining slots to confirm that they hold until their reply arrives.

// File: rtl/msl_pkg.sv
package msl_pkg;
    typedef enum logic [2:0] {
        ST_FREE      = 3'd0,
        ST_READY     = 3'd1,
        ST_TLB_WAIT  = 3'd2,
        ST_MEM_WAIT  = 3'd3,
        ST_DRAIN_TLB = 3'd4,
        ST_DRAIN_MEM = 3'd5
    } slot_st_e;
endpackage

// File: rtl/msl_slot.sv
module msl_slot
    import msl_pkg::*;
#(
    parameter int TID_W = 1,
    parameter int SEQ_W = 8,
    parameter int IDX_W = 3,
    parameter int CMD_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_we,
    input  logic [TID_W-1:0] alloc_tid,
    input  logic [SEQ_W-1:0] alloc_seq,
    input  logic [IDX_W-1:0] alloc_idx,
    input  logic [CMD_W-1:0] alloc_cmd,
    input  logic             ev_tlb_miss,
    input  logic             ev_tlb_done,
    input  logic             ev_issue,
    input  logic             ev_chk,
    input  logic             ev_rsp,
    input  logic             ev_free,
    input  logic             sq_vld,
    input  logic [TID_W-1:0] sq_tid,
    input  logic [SEQ_W:0]   sq_thr_eff,
    output logic             busy_o,
    output logic             sqd_o,
    output logic             done_o,
    output logic             mstall_o,
    output logic [TID_W-1:0] tid_o,
    output logic [SEQ_W-1:0] seq_o,
    output logic [IDX_W-1:0] idx_o,
    output logic [CMD_W-1:0] cmd_o,
    output logic             fwd_o,
    output logic             tlb_set_o,
    output logic             tlb_clr_o
);
    slot_st_e         st_q, st_d;
    logic [TID_W-1:0] tid_q;
    logic [SEQ_W-1:0] seq_q;
    logic [IDX_W-1:0] idx_q;
    logic [CMD_W-1:0] cmd_q;
    logic             done_q, mstall_q;
    logic             live, sq_hit;

    assign live   = (st_q == ST_READY) || (st_q == ST_TLB_WAIT) || (st_q == ST_MEM_WAIT);
    assign sq_hit = sq_vld && live && (tid_q == sq_tid) && ({1'b0, seq_q} > sq_thr_eff);

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_FREE:      if (alloc_we) st_d = ST_READY;
            ST_READY: begin
                if (sq_hit || ev_free) st_d = ST_FREE;
                else if (ev_tlb_miss)  st_d = ST_TLB_WAIT;
                else if (ev_issue)     st_d = ST_MEM_WAIT;
            end
            ST_TLB_WAIT: begin
                if (ev_tlb_done)  st_d = sq_hit ? ST_FREE : ST_READY;
                else if (sq_hit)  st_d = ST_DRAIN_TLB;
            end
            ST_MEM_WAIT: begin
                if (ev_rsp)       st_d = sq_hit ? ST_FREE : ST_READY;
                else if (sq_hit)  st_d = ST_DRAIN_MEM;
            end
            ST_DRAIN_TLB: if (ev_tlb_done) st_d = ST_FREE;
            ST_DRAIN_MEM: if (ev_rsp)      st_d = ST_FREE;
            default:      st_d = ST_FREE;
        endcase
    end

    // state register and slot fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_FREE;
            tid_q    <= '0;
            seq_q    <= '0;
            idx_q    <= '0;
            cmd_q    <= '0;
            done_q   <= 1'b0;
            mstall_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_FREE && alloc_we) begin
                tid_q    <= alloc_tid;
                seq_q    <= alloc_seq;
                idx_q    <= alloc_idx;
                cmd_q    <= alloc_cmd;
                done_q   <= 1'b0;
                mstall_q <= 1'b0;
            end else if ((st_q == ST_MEM_WAIT || st_q == ST_DRAIN_MEM) && ev_rsp) begin
                done_q   <= 1'b1;
                mstall_q <= 1'b0;
            end else if (st_q == ST_MEM_WAIT && ev_chk) begin
                done_q   <= 1'b0;
                mstall_q <= 1'b1;
            end else if (st_q == ST_READY && ev_issue) begin
                done_q   <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        busy_o    = (st_q != ST_FREE);
        sqd_o     = (st_q == ST_DRAIN_TLB) || (st_q == ST_DRAIN_MEM);
        done_o    = busy_o && done_q;
        mstall_o  = busy_o && mstall_q;
        tid_o     = tid_q;
        seq_o     = seq_q;
        idx_o     = idx_q;
        cmd_o     = cmd_q;
        fwd_o     = ev_rsp && (st_q == ST_MEM_WAIT);
        tlb_set_o = ev_tlb_miss && (st_q == ST_READY) && !sq_hit && !ev_free;
        tlb_clr_o = (st_q == ST_TLB_WAIT) && (ev_tlb_done || sq_hit);
    end

    // R6: a draining slot holds until its reply
    p_drain_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DRAIN_MEM && !ev_rsp) |=> (st_q == ST_DRAIN_MEM));
    // R9: reply to a squashed slot releases it
    p_drain_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DRAIN_MEM && ev_rsp) |=> (st_q == ST_FREE));
    // R8: check without reply marks memory stall
    p_chk_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_MEM_WAIT && ev_chk && !ev_rsp && !sq_hit) |=> (mstall_o && !done_o));
    // R7: a squashed slot never returns to a live state without release
    p_sqd_stays_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sqd_o |=> (sqd_o || st_q == ST_FREE));
endmodule

// File: rtl/msl_pick.sv
module msl_pick #(
    parameter int NSLOTS = 4,
    localparam int SLOT_W = (NSLOTS > 1) ? $clog2(NSLOTS) : 1
) (
    input  logic [NSLOTS-1:0] busy,
    output logic              any_free,
    output logic [SLOT_W-1:0] pick
);
    always_comb begin
        any_free = 1'b0;
        pick     = '0;
        for (int i = NSLOTS - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                any_free = 1'b1;
                pick     = SLOT_W'(i);
            end
        end
    end
endmodule

// File: rtl/msl_match.sv
module msl_match #(
    parameter int NSLOTS = 4,
    parameter int SEQ_W  = 8,
    parameter int IDX_W  = 3,
    localparam int SLOT_W = (NSLOTS > 1) ? $clog2(NSLOTS) : 1
) (
    input  logic [NSLOTS-1:0]            busy,
    input  logic [NSLOTS-1:0][SEQ_W-1:0] seq,
    input  logic [NSLOTS-1:0][IDX_W-1:0] idx,
    input  logic [SEQ_W-1:0]             key_seq,
    input  logic [IDX_W-1:0]             key_idx,
    output logic                         hit,
    output logic [SLOT_W-1:0]            slot
);
    logic [NSLOTS-1:0] m;

    for (genvar g = 0; g < NSLOTS; g++) begin : g_cmp
        assign m[g] = busy[g] && (seq[g] == key_seq) && (idx[g] == key_idx);
    end

    always_comb begin
        hit  = |m;
        slot = '0;
        for (int i = NSLOTS - 1; i >= 0; i--) begin
            if (m[i]) slot = SLOT_W'(i);
        end
    end
endmodule

// File: rtl/mem_slot_table.sv
module mem_slot_table #(
    parameter int NSLOTS = 4,
    parameter int TID_W  = 1,
    parameter int SEQ_W  = 8,
    parameter int IDX_W  = 3,
    parameter int CMD_W  = 2,
    localparam int SLOT_W = (NSLOTS > 1) ? $clog2(NSLOTS) : 1,
    localparam int NTHR   = 1 << TID_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_req,
    input  logic [TID_W-1:0]  alloc_tid,
    input  logic [SEQ_W-1:0]  alloc_seq,
    input  logic [IDX_W-1:0]  alloc_idx,
    input  logic [CMD_W-1:0]  alloc_cmd,
    output logic              alloc_gnt,
    output logic [SLOT_W-1:0] alloc_slot,
    input  logic [SEQ_W-1:0]  lk_seq,
    input  logic [IDX_W-1:0]  lk_idx,
    output logic              lk_hit,
    output logic [SLOT_W-1:0] lk_slot,
    input  logic [NSLOTS-1:0] tlb_miss_mask,
    input  logic [NSLOTS-1:0] tlb_done_mask,
    input  logic [NSLOTS-1:0] issue_mask,
    input  logic [NSLOTS-1:0] chk_mask,
    input  logic [NSLOTS-1:0] rsp_mask,
    input  logic [NSLOTS-1:0] free_mask,
    input  logic              sq_vld,
    input  logic [TID_W-1:0]  sq_tid,
    input  logic [SEQ_W-1:0]  sq_thr,
    input  logic              sq_memstall,
    output logic [NSLOTS-1:0] rsp_fwd,
    output logic [NSLOTS-1:0] slot_busy,
    output logic [NSLOTS-1:0] slot_sqd,
    output logic [NSLOTS-1:0] slot_done,
    output logic [NSLOTS-1:0] slot_mstall,
    output logic [NTHR-1:0]   thr_blocked
);
    logic [NSLOTS-1:0][TID_W-1:0] s_tid;
    logic [NSLOTS-1:0][SEQ_W-1:0] s_seq;
    logic [NSLOTS-1:0][IDX_W-1:0] s_idx;
    logic [NSLOTS-1:0][CMD_W-1:0] s_cmd;
    logic [NSLOTS-1:0]            s_tset, s_tclr;
    logic [SEQ_W:0]               thr_eff;
    logic                         any_free;
    logic [SLOT_W-1:0]            pick;
    logic [NTHR-1:0]              blk_q, blk_set, blk_clr;

    assign thr_eff    = {1'b0, sq_thr} + {{SEQ_W{1'b0}}, sq_memstall};
    assign alloc_gnt  = alloc_req && any_free && !blk_q[alloc_tid];
    assign alloc_slot = pick;

    msl_pick #(.NSLOTS(NSLOTS)) u_pick (
        .busy(slot_busy), .any_free(any_free), .pick(pick)
    );

    msl_match #(.NSLOTS(NSLOTS), .SEQ_W(SEQ_W), .IDX_W(IDX_W)) u_match (
        .busy(slot_busy), .seq(s_seq), .idx(s_idx),
        .key_seq(lk_seq), .key_idx(lk_idx), .hit(lk_hit), .slot(lk_slot)
    );

    for (genvar g = 0; g < NSLOTS; g++) begin : g_slot
        msl_slot #(.TID_W(TID_W), .SEQ_W(SEQ_W), .IDX_W(IDX_W), .CMD_W(CMD_W)) u_slot (
            .clk(clk), .rst_n(rst_n),
            .alloc_we(alloc_gnt && (pick == SLOT_W'(g))),
            .alloc_tid(alloc_tid), .alloc_seq(alloc_seq),
            .alloc_idx(alloc_idx), .alloc_cmd(alloc_cmd),
            .ev_tlb_miss(tlb_miss_mask[g]), .ev_tlb_done(tlb_done_mask[g]),
            .ev_issue(issue_mask[g]), .ev_chk(chk_mask[g]),
            .ev_rsp(rsp_mask[g]), .ev_free(free_mask[g]),
            .sq_vld(sq_vld), .sq_tid(sq_tid), .sq_thr_eff(thr_eff),
            .busy_o(slot_busy[g]), .sqd_o(slot_sqd[g]),
            .done_o(slot_done[g]), .mstall_o(slot_mstall[g]),
            .tid_o(s_tid[g]), .seq_o(s_seq[g]), .idx_o(s_idx[g]), .cmd_o(s_cmd[g]),
            .fwd_o(rsp_fwd[g]), .tlb_set_o(s_tset[g]), .tlb_clr_o(s_tclr[g])
        );
    end

    // per-thread translation block
    always_comb begin
        blk_set = '0;
        blk_clr = '0;
        for (int i = 0; i < NSLOTS; i++) begin
            if (s_tset[i]) blk_set[s_tid[i]] = 1'b1;
            if (s_tclr[i]) blk_clr[s_tid[i]] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) blk_q <= '0;
        else        blk_q <= (blk_q & ~blk_clr) | blk_set;
    end

    assign thr_blocked = blk_q;

    // R2: a granted slot is held on the next cycle
    p_alloc_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_gnt |=> slot_busy[$past(alloc_slot)]);
    // R10: a blocked thread gets no slot
    p_blocked_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req && thr_blocked[alloc_tid]) |-> !alloc_gnt);
    // R9: no forwarding from a squashed slot
    p_no_fwd_sqd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_fwd & slot_sqd) == '0);
endmodule

// File: tb/mem_slot_table_tb.sv
module mem_slot_table_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       alloc_req = 0;
    logic [0:0] alloc_tid = 0;
    logic [7:0] alloc_seq = 0;
    logic [2:0] alloc_idx = 0;
    logic [1:0] alloc_cmd = 0;
    logic       alloc_gnt;
    logic [1:0] alloc_slot;
    logic [7:0] lk_seq = 0;
    logic [2:0] lk_idx = 0;
    logic       lk_hit;
    logic [1:0] lk_slot;
    logic [N-1:0] tlb_miss_mask = 0, tlb_done_mask = 0, issue_mask = 0;
    logic [N-1:0] chk_mask = 0, rsp_mask = 0, free_mask = 0;
    logic       sq_vld = 0;
    logic [0:0] sq_tid = 0;
    logic [7:0] sq_thr = 0;
    logic       sq_memstall = 0;
    logic [N-1:0] rsp_fwd, slot_busy, slot_sqd, slot_done, slot_mstall;
    logic [1:0] thr_blocked;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mem_slot_table dut_i (
        .clk(clk), .rst_n(rst_n),
        .alloc_req(alloc_req), .alloc_tid(alloc_tid), .alloc_seq(alloc_seq),
        .alloc_idx(alloc_idx), .alloc_cmd(alloc_cmd),
        .alloc_gnt(alloc_gnt), .alloc_slot(alloc_slot),
        .lk_seq(lk_seq), .lk_idx(lk_idx), .lk_hit(lk_hit), .lk_slot(lk_slot),
        .tlb_miss_mask(tlb_miss_mask), .tlb_done_mask(tlb_done_mask),
        .issue_mask(issue_mask), .chk_mask(chk_mask), .rsp_mask(rsp_mask),
        .free_mask(free_mask), .sq_vld(sq_vld), .sq_tid(sq_tid), .sq_thr(sq_thr),
        .sq_memstall(sq_memstall), .rsp_fwd(rsp_fwd), .slot_busy(slot_busy),
        .slot_sqd(slot_sqd), .slot_done(slot_done), .slot_mstall(slot_mstall),
        .thr_blocked(thr_blocked)
    );

    task automatic ck(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        alloc_req = 0; tlb_miss_mask = 0; tlb_done_mask = 0; issue_mask = 0;
        chk_mask = 0; rsp_mask = 0; free_mask = 0; sq_vld = 0; sq_memstall = 0;
    endtask

    // request an allocation; check grant combinationally, then commit
    task automatic alloc(input int tid, input int seq, input int idx,
                         input int exp_gnt, input int exp_slot, input string req);
        alloc_req = 1; alloc_tid = 1'(tid); alloc_seq = 8'(seq);
        alloc_idx = 3'(idx); alloc_cmd = 2'(idx);
        #1;
        ck(req, int'(alloc_gnt), exp_gnt);
        if (exp_gnt != 0) ck(req, int'(alloc_slot), exp_slot);
        step();
    endtask

    task automatic squash(input int tid, input int thr, input int mflag);
        sq_vld = 1; sq_tid = 1'(tid); sq_thr = 8'(thr); sq_memstall = mflag[0];
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset state
        ck("R1 busy", int'(slot_busy), 0);
        ck("R1 blocked", int'(thr_blocked), 0);
        ck("R1 sqd", int'(slot_sqd | slot_done | slot_mstall), 0);

        // R2 fill in order: slot k gets tid k%2, seq 10+k, idx k
        for (int k = 0; k < N; k++) alloc(k % 2, 10 + k, k, 1, k, "R2 fill");
        ck("R2 busy", int'(slot_busy), 15);
        ck("R2 fresh done", int'(slot_done | slot_mstall), 0);
        alloc(0, 99, 0, 0, 0, "R2 full");
        ck("R2 full unchanged", int'(slot_busy), 15);

        // R3 lookup sweep over every slot and index
        for (int s = 0; s < N; s++) begin
            for (int i = 0; i < 8; i++) begin
                lk_seq = 8'(10 + s); lk_idx = 3'(i);
                #1;
                ck("R3 hit", int'(lk_hit), (i == s) ? 1 : 0);
                if (i == s) ck("R3 slot", int'(lk_slot), s);
            end
            lk_seq = 8'(50); lk_idx = 3'(s);
            #1;
            ck("R3 tag miss", int'(lk_hit), 0);
        end

        // R12 free two slots at once; lowest index reused first (R2)
        free_mask = 4'b0110;
        step();
        ck("R12 free pair", int'(slot_busy), 9);
        alloc(0, 20, 1, 1, 1, "R2 lowest free");
        alloc(1, 21, 2, 1, 2, "R2 next free");

        // R8 issue all, check slot 0 with no reply
        issue_mask = 4'b1111;
        step();
        chk_mask = 4'b0001;
        step();
        ck("R8 mstall", int'(slot_mstall[0]), 1);
        ck("R8 not done", int'(slot_done[0]), 0);
        rsp_mask = 4'b0001;
        #1;
        ck("R8 fwd", int'(rsp_fwd[0]), 1);
        step();
        ck("R8 done", int'(slot_done[0]), 1);
        ck("R8 mstall clear", int'(slot_mstall[0]), 0);

        // R4 R6 squash tid1 above 12: slots 2 (seq21) and 3 (seq13), both pending
        squash(1, 12, 0);
        step();
        ck("R4 sqd", int'(slot_sqd), 12);
        ck("R6 held", int'(slot_busy), 15);

        // R7 further squash on draining slots has no effect
        squash(1, 0, 0);
        step();
        ck("R7 still held", int'(slot_busy), 15);
        ck("R7 still sqd", int'(slot_sqd), 12);

        // R9 reply to squashed slot 2 is dropped and slot released
        rsp_mask = 4'b0100;
        #1;
        ck("R9 no fwd", int'(rsp_fwd[2]), 0);
        step();
        ck("R9 released", int'(slot_busy), 11);

        // R4 memstall flag: threshold 19+1, slot1 seq20 survives
        squash(0, 19, 1);
        step();
        ck("R4 survives", int'(slot_sqd[1]), 0);
        ck("R4 survives busy", int'(slot_busy[1]), 1);

        // R11 squash and reply together on slot 1 (MEM_WAIT, seq 20 > 19)
        squash(0, 19, 0);
        rsp_mask = 4'b0010;
        #1;
        ck("R11 fwd", int'(rsp_fwd[1]), 1);
        step();
        ck("R11 freed", int'(slot_busy[1]), 0);

        // R5 READY slot 0 (tid0 seq10) squashed above 9 frees at once
        squash(0, 9, 0);
        step();
        ck("R5 freed", int'(slot_busy[0]), 0);
        rsp_mask = 4'b1000;
        step();
        ck("R6 drained", int'(slot_busy), 0);

        // R10 translation block
        alloc(1, 30, 0, 1, 0, "R2 after drain");
        alloc(0, 31, 1, 1, 1, "R2 after drain b");
        tlb_miss_mask = 4'b0001;
        step();
        ck("R10 blocked", int'(thr_blocked), 2);
        alloc(1, 40, 3, 0, 0, "R10 refused");
        alloc(0, 32, 2, 1, 2, "R10 other thread");
        tlb_done_mask = 4'b0001;
        step();
        ck("R10 resume", int'(thr_blocked), 0);
        tlb_miss_mask = 4'b0001;
        step();
        ck("R10 blocked again", int'(thr_blocked), 2);
        squash(1, 0, 0);
        step();
        ck("R10 squash unblocks", int'(thr_blocked), 0);
        ck("R6 tlb held", int'(slot_busy[0]), 1);
        ck("R6 tlb sqd", int'(slot_sqd[0]), 1);
        tlb_done_mask = 4'b0001;
        step();
        ck("R6 tlb released", int'(slot_busy[0]), 0);

        finished = 1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule